// File: doc/BRIEF.md
# DRAM Auto-Refresh Interval Timer

This block decides when a DRAM controller must run an auto-refresh. Software programs an 8-bit interval count into a 16-bit configuration register. For any non-zero count the block raises a refresh request once every count × 16 clock cycles. A count of zero selects continuous refresh. In that mode the request never drops, and read/write traffic is locked out entirely.

The block also arbitrates between refresh and host read/write requests. Refresh wins whenever it is pending. An access that is already in progress, signalled by `acc_busy`, is never interrupted: the refresh waits for it to finish. The start strobe goes to the command sequencer, and a pending request clears in the cycle the strobe is given.

A new count normally takes effect only when the current interval runs out. Software can force it in at once by writing a rising edge on the load bit. The load bit keeps the value written to it.

Top module: `dram_refresh_timer`

## Requirements
- R1: Register layout: bits 7:0 hold the refresh count and bit 8 holds the load bit. Bits 15:9 always read 0, and writes to them are ignored. A read returns the stored count and load bit.
- R2: With a non-zero count N that is neither reloaded nor changed, `rfsh_req` rises exactly N × 16 cycles after the previous rise, provided each request is taken at once.
- R3: After reset the register reads 0x0000, and because the count is 0 the block is in continuous refresh (`rfsh_req` = 1).
- R4: While the stored count is 0, `rfsh_req` stays 1 and `acc_grant` stays 0 whatever `acc_req` does.
- R5: `rfsh_start` is 1 exactly when `rfsh_req` = 1 and `acc_busy` = 0. While `acc_busy` = 1, neither `rfsh_start` nor `acc_grant` is given.
- R6: A write whose bit 8 is 1 while the stored load bit is 0 loads the written count into the interval counter at that clock edge. The next request then rises N × 16 cycles after that edge.
- R7: The load bit holds its written value. Writing 1 while it already reads 1 causes no reload. Writing 0 and then 1 does reload.
- R8: A count changed without a load-bit edge leaves the running interval to expire on its old schedule. Every interval after that uses the new count.
- R9: A pending request stays asserted until `rfsh_start` is given. Intervals that expire while the request is pending do not queue extra refreshes, so one start serves them all.
- R10: `acc_grant` = `acc_req` AND NOT `acc_busy` AND NOT `rfsh_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 16 | Register write data |
| cfg_rd_data | output | 16 | Register read data |
| acc_req | input | 1 | Host read/write request pending |
| acc_busy | input | 1 | A DRAM access is in progress |
| rfsh_req | output | 1 | Refresh wanted (pending or continuous) |
| rfsh_start | output | 1 | Sequencer may start a refresh this cycle |
| acc_grant | output | 1 | Host read/write may start this cycle |

## Verification
The following are checked on every cycle:
- the arbitration invariants: no start or grant while `acc_busy` is high, and start and grant never high together;
- no grant in continuous mode;
- the counter stepping down by one, reloading with count × 16 − 1 on expiry or on a load;
- a pending request holding until it is taken.

The exact interval lengths are shown only by the bench's scenarios. These include the old-period finish after a count change, the 0-then-1 reload sequence, and the single start that follows a long busy stretch covering two expiries.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int CNT_W = 8;
  localparam int SHIFT = 4;
  localparam int TMR_W = CNT_W + SHIFT;
  localparam int REG_W = 16;

  // Value loaded into the down-counter: count*16 - 1, or 0 for continuous mode
  function automatic logic [TMR_W-1:0] reload_of(input logic [CNT_W-1:0] c);
    logic [TMR_W-1:0] t;
    t = {c, {SHIFT{1'b0}}};
    if (c == '0) return '0;
    return t - TMR_W'(1);
  endfunction
endpackage

// File: rtl/rfsh_cfg_reg.sv
module rfsh_cfg_reg #(
  parameter int REG_W = rfsh_pkg::REG_W,
  parameter int CNT_W = rfsh_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_q,
  output logic             load_pulse,
  output logic [CNT_W-1:0] load_count
);
  localparam int LD_BIT = CNT_W;

  logic ld_q;

  assign load_pulse = wr_en & wr_data[LD_BIT] & ~ld_q;
  assign load_count = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ld_q    <= 1'b0;
    end else if (wr_en) begin
      count_q <= wr_data[CNT_W-1:0];
      ld_q    <= wr_data[LD_BIT];
    end
  end

  always_comb begin
    rd_data             = '0;
    rd_data[CNT_W-1:0]  = count_q;
    rd_data[LD_BIT]     = ld_q;
  end

  AST_LOAD_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> rd_data[LD_BIT]);                                   // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));                                      // R7
endmodule

// File: rtl/rfsh_interval_ctr.sv
module rfsh_interval_ctr #(
  parameter int CNT_W = rfsh_pkg::CNT_W,
  parameter int TMR_W = rfsh_pkg::TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_q,
  input  logic             load_pulse,
  input  logic [CNT_W-1:0] load_count,
  output logic             expire,
  output logic             cont_mode
);
  import rfsh_pkg::reload_of;

  logic [TMR_W-1:0] ctr_q;

  assign cont_mode = (count_q == '0);
  assign expire    = !cont_mode && (ctr_q == '0) && !load_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n)          ctr_q <= '0;
    else if (load_pulse) ctr_q <= reload_of(load_count);
    else if (cont_mode)  ctr_q <= '0;
    else if (ctr_q == '0) ctr_q <= reload_of(count_q);
    else                 ctr_q <= ctr_q - TMR_W'(1);
  end

  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (ctr_q == reload_of($past(count_q))));                  // R8
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode && ctr_q != '0 && !load_pulse) |=> (ctr_q == $past(ctr_q) - TMR_W'(1))); // R2
  AST_FORCED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (ctr_q == reload_of($past(load_count))));           // R6
endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic cont_mode,
  input  logic expire,
  input  logic acc_req,
  input  logic acc_busy,
  output logic rfsh_req,
  output logic rfsh_start,
  output logic acc_grant
);
  logic pend_q;

  assign rfsh_req   = cont_mode | pend_q;
  assign rfsh_start = rfsh_req & ~acc_busy;
  assign acc_grant  = acc_req & ~acc_busy & ~rfsh_req;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (cont_mode) pend_q <= 1'b0;
    else                pend_q <= (pend_q & ~rfsh_start) | expire;
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_busy |-> !(rfsh_start || acc_grant));                          // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh_start && acc_grant));                                       // R5
  AST_CONT_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    cont_mode |-> (rfsh_req && !acc_grant));                           // R4
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rfsh_start) |=> (pend_q || cont_mode));                // R9
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REG_W = rfsh_pkg::REG_W,
  parameter int CNT_W = rfsh_pkg::CNT_W,
  parameter int TMR_W = rfsh_pkg::TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             acc_req,
  input  logic             acc_busy,
  output logic             rfsh_req,
  output logic             rfsh_start,
  output logic             acc_grant
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_count;
  logic             load_pulse;
  logic             expire;
  logic             cont_mode;

  rfsh_cfg_reg #(.REG_W(REG_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .count_q(count_q), .load_pulse(load_pulse),
    .load_count(load_count)
  );

  rfsh_interval_ctr #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .count_q(count_q), .load_pulse(load_pulse),
    .load_count(load_count), .expire(expire), .cont_mode(cont_mode)
  );

  rfsh_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode), .expire(expire),
    .acc_req(acc_req), .acc_busy(acc_busy), .rfsh_req(rfsh_req),
    .rfsh_start(rfsh_start), .acc_grant(acc_grant)
  );

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[REG_W-1:CNT_W+1] == '0);                               // R1
endmodule

// File: tb/sim_dram_refresh_timer.sv
module sim_dram_refresh_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        acc_req = 1'b0;
  logic        acc_busy = 1'b0;
  logic        rfsh_req, rfsh_start, acc_grant;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_refresh_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .acc_req(acc_req), .acc_busy(acc_busy),
    .rfsh_req(rfsh_req), .rfsh_start(rfsh_start), .acc_grant(acc_grant)
  );

  function automatic int period_of(input int n);
    return n << 4;
  endfunction

  function automatic logic [15:0] readback_of(input logic [15:0] d);
    return {7'd0, d[8], d[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_next(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rfsh_req && k < 10000);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k;
    int starts;
    logic [15:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state
    check("R3 readback", cfg_rd_data, 16'h0000);
    check("R3 continuous req", rfsh_req, 1'b1);
    acc_req = 1'b1; #1;
    check("R4 no grant in continuous", acc_grant, 1'b0);
    check("R5 start when idle", rfsh_start, 1'b1);
    acc_req = 1'b0;

    // R6 forced load, R2 period
    wr(16'h0103);
    check("R6 req low after load", rfsh_req, 1'b0);
    wait_next(k);
    check("R6 first interval", k, period_of(3));
    wait_next(k);
    check("R2 period N=3", k, period_of(3));
    acc_req = 1'b1; #1;
    check("R10 no grant during req", acc_grant, 1'b0);
    check("R5 start on req", rfsh_start, 1'b1);
    @(negedge clk); #1;
    check("R10 grant when idle", acc_grant, 1'b1);
    acc_busy = 1'b1; #1;
    check("R5 busy blocks grant", acc_grant, 1'b0);
    acc_busy = 1'b0; acc_req = 1'b0;

    // R8 / R7: change count with load bit already 1
    repeat (4) @(negedge clk);
    wr(16'h0105);
    check("R7 bit held", cfg_rd_data, 16'h0105);
    wait_next(k);
    check("R8 old period finishes", k, period_of(3) - 6);
    wait_next(k);
    check("R8 new period", k, period_of(5));

    // R7: 0 then 1 reloads
    wr(16'h0002);
    wr(16'h0102);
    wait_next(k);
    check("R7 reload after 0-then-1", k, period_of(2));

    // R9: pending held through busy, no queueing
    starts = 0;
    @(negedge clk);
    acc_busy = 1'b1;
    for (int i = 2; i <= 70; i++) begin
      @(negedge clk);
      if (rfsh_start) starts++;
    end
    check("R5 no start while busy", starts, 0);
    check("R9 req held", rfsh_req, 1'b1);
    acc_busy = 1'b0; #1;
    check("R9 start on release", rfsh_start, 1'b1);
    starts = 0;
    for (int i = 71; i <= 95; i++) begin
      @(negedge clk);
      if (rfsh_start) starts++;
    end
    check("R9 no queued refresh", starts, 0);
    @(negedge clk);
    check("R9 next expiry on schedule", rfsh_start, 1'b1);

    // R1 random register writes
    for (int i = 0; i < 30; i++) begin
      d = 16'($urandom);
      wr(d);
      check("R1 readback", cfg_rd_data, readback_of(d));
    end

    // R4 random traffic in continuous mode
    wr(16'h0000);
    for (int i = 0; i < 30; i++) begin
      acc_req = 1'($urandom); acc_busy = 1'($urandom); #1;
      check("R4 req stays", rfsh_req, 1'b1);
      check("R4 grant locked", acc_grant, 1'b0);
      check("R5 start", rfsh_start, !acc_busy);
      @(negedge clk);
    end

    // R10 random traffic in long-period mode
    wr(16'h00FF);
    wr(16'h01FF);
    for (int i = 0; i < 30; i++) begin
      acc_req = 1'($urandom); acc_busy = 1'($urandom); #1;
      check("R2 no early req", rfsh_req, 1'b0);
      check("R10 grant", acc_grant, acc_req & !acc_busy);
      @(negedge clk);
    end
    acc_req = 1'b0; acc_busy = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule